// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Host Sequencer

This block is the host-side controller for a six-channel, 16-bit converter that samples channel pairs simultaneously and is driven over a parallel bus in software-selection mode. A one-cycle start request latches a configuration: three pair-select bits, three per-pair range bits and two reference options. The block first writes these as an 8-bit control byte on the upper data lines. If any pair is selected, it then pulses the first conversion-start line and waits for the converter's busy signal to rise and then fall. After that it issues exactly as many read strobes as the selection and the word/byte mode need.

Results leave the block as a stream of 16-bit words in ascending channel order. Each word is tagged with a channel index, and the final channel of the frame carries a last flag. The shared data bus is split into an input, an output and an output-enable. The block enables its drivers only during the control write and releases them before any read. The strobe widths come from cycle-count parameters.

Top module: `adc_host_seq`

## Requirements
- R1: On start, the control byte is driven on dbOut[15:8] as {pairSel[2], pairSel[1], pairSel[0], range[2], range[1], range[0], intRef, bufBypass}, and dbOut[7:0] is 0. While wrN is low, csN is low, rdN is high and dbOe is high. Pair index p covers channels 2p and 2p+1.
- R2: dbOut and dbOe=1 are held unchanged on the cycle where wrN rises, so the converter captures a stable byte.
- R3: During and right after reset, csN, wrN and rdN are high, convstA, dbOe, resValid and done are low.
- R4: With at least one pair selected, convstA gives exactly one high pulse per frame, after the control write. convstB and convstC stay low at all times.
- R5: No read strobe is asserted while busy is high. The number of read strobes per frame is 2 × (selected pairs) in word mode and 4 × (selected pairs) in byte mode.
- R6: dbOe is low in the cycle before every falling edge of rdN, and dbOe is never high while rdN is low.
- R7: In word mode each result equals dbIn as sampled at the end of its read strobe. Results come in ascending channel order, and resChan holds the channel index 0..5.
- R8: In byte mode (byteMode=1) each channel takes two reads on dbIn[7:0], the high byte first. The result is {first byte, second byte}, and dbIn[15:8] is ignored.
- R9: resLast is high only together with resValid, and only on the final channel of the frame.
- R10: With no pair selected, the control byte is still written, but there is no convstA pulse and no read strobe. done pulses with zero results.
- R11: done is a one-cycle pulse after the frame's last result. A start request made while a frame is in progress is ignored and causes no second control write.
- R12: wrN stays low for exactly WR_CYC cycles per write, and rdN stays low for exactly RD_CYC cycles per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle frame request |
| cfgPairSel | input | 3 | Pair-select bits, bit p selects channels 2p and 2p+1 |
| cfgRange | input | 3 | Per-pair range (1 selects ±2×Vref, 0 selects ±4×Vref) |
| cfgIntRef | input | 1 | Internal reference enable |
| cfgBufBypass | input | 1 | Reference buffer bypass |
| byteMode | input | 1 | 1 selects two byte reads per channel |
| busy | input | 1 | Converter conversion-in-progress flag |
| dbIn | input | 16 | Data bus from the converter |
| dbOut | output | 16 | Data bus toward the converter |
| dbOe | output | 1 | Host bus driver enable |
| csN | output | 1 | Chip select, active low |
| wrN | output | 1 | Write strobe, active low |
| rdN | output | 1 | Read strobe, active low |
| convstA | output | 1 | Conversion start, rising edge starts conversion |
| convstB | output | 1 | Second start line, held low |
| convstC | output | 1 | Third start line, held low |
| resValid | output | 1 | Result word valid |
| resData | output | 16 | Result word |
| resChan | output | 3 | Channel index of the result |
| resLast | output | 1 | Final channel of the frame |
| done | output | 1 | Frame complete pulse |

## Verification
The main function runs with several selections. All three pairs shows the full ascending sweep. Selections of pairs 0 and 2, and of pair 1 alone, show that the index skips unselected pairs and that the last flag tracks the highest selected pair. Word and byte modes run with different data seeds, which separates correct byte merging (and high-byte-first order) from a swapped or unmasked bus. An empty selection exercises the skip path. A second start during a frame, and a byte with mixed range and reference bits, confirm that the request is ignored mid-frame and that each bit lands in its position.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic latchCfg;
    logic sampleRd;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic noPairs;
    logic frameDone;
  } seqStatus_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WR_CYC    = 2,
  parameter int HOLD_CYC  = 1,
  parameter int CONV_CYC  = 2,
  parameter int RD_CYC    = 2,
  parameter int RDH_CYC   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       busy,
  input  seqStatus_t stat,
  output seqStrobe_t strb,
  output logic       csN,
  output logic       wrN,
  output logic       rdN,
  output logic       convst,
  output logic       dbOe,
  output logic       done
);
  localparam int MAX_A = (SETUP_CYC > WR_CYC) ? SETUP_CYC : WR_CYC;
  localparam int MAX_B = (HOLD_CYC > CONV_CYC) ? HOLD_CYC : CONV_CYC;
  localparam int MAX_C = (RD_CYC > RDH_CYC) ? RD_CYC : RDH_CYC;
  localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAXT = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CNTW = (MAXT < 2) ? 1 : $clog2(MAXT);

  typedef enum logic [3:0] {
    S_IDLE, S_WSET, S_WLOW, S_WHLD, S_CONV, S_BUSYH, S_BUSYL,
    S_TURN, S_RLOW, S_RHIGH, S_FIN
  } state_t;

  state_t st, stNext;
  logic [CNTW-1:0] cnt, cntNext;

  function automatic logic [CNTW-1:0] ld(input int n);
    return CNTW'((n < 1) ? 0 : n - 1);
  endfunction

  always_comb begin
    stNext  = st;
    cntNext = (cnt != '0) ? cnt - 1'b1 : cnt;
    strb    = '0;
    csN     = 1'b1;
    wrN     = 1'b1;
    rdN     = 1'b1;
    convst  = 1'b0;
    dbOe    = 1'b0;
    done    = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        strb.latchCfg = 1'b1;
        stNext  = S_WSET;
        cntNext = ld(SETUP_CYC);
      end
      S_WSET: begin
        csN = 1'b0; dbOe = 1'b1;
        if (cnt == '0) begin stNext = S_WLOW; cntNext = ld(WR_CYC); end
      end
      S_WLOW: begin
        csN = 1'b0; wrN = 1'b0; dbOe = 1'b1;
        if (cnt == '0) begin stNext = S_WHLD; cntNext = ld(HOLD_CYC); end
      end
      S_WHLD: begin
        csN = 1'b0; dbOe = 1'b1;
        if (cnt == '0) begin
          if (stat.noPairs) stNext = S_FIN;
          else begin stNext = S_CONV; cntNext = ld(CONV_CYC); end
        end
      end
      S_CONV: begin
        convst = 1'b1;
        if (cnt == '0) stNext = S_BUSYH;
      end
      S_BUSYH: if (busy) stNext = S_BUSYL;
      S_BUSYL: if (!busy) stNext = S_TURN;
      S_TURN: begin
        csN = 1'b0;
        stNext  = S_RLOW;
        cntNext = ld(RD_CYC);
      end
      S_RLOW: begin
        csN = 1'b0; rdN = 1'b0;
        if (cnt == '0) begin
          strb.sampleRd = 1'b1;
          stNext  = S_RHIGH;
          cntNext = ld(RDH_CYC);
        end
      end
      S_RHIGH: begin
        csN = 1'b0;
        if (cnt == '0) begin
          if (stat.frameDone) stNext = S_FIN;
          else begin stNext = S_RLOW; cntNext = ld(RD_CYC); end
        end
      end
      S_FIN: begin
        done   = 1'b1;
        stNext = S_IDLE;
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= stNext;
      cnt <= cntNext;
    end
  end
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int NPAIRS = 3,
  parameter int DW     = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqStrobe_t                    strb,
  input  logic [2*NPAIRS+1:0]           cfgIn,
  input  logic                          byteModeIn,
  input  logic [DW-1:0]                 dbIn,
  output logic [DW-1:0]                 dbOut,
  output seqStatus_t                    stat,
  output logic                          resValid,
  output logic [DW-1:0]                 resData,
  output logic [$clog2(2*NPAIRS)-1:0]   resChan,
  output logic                          resLast
);
  localparam int CFGW = 2 * NPAIRS + 2;
  localparam int CHW  = $clog2(2 * NPAIRS);
  localparam int PW   = (CHW > 1) ? CHW - 1 : 1;
  localparam int HW   = DW / 2;

  logic [CFGW-1:0] cfgQ;
  logic            byteQ;
  logic [CHW-1:0]  chanIdx, chanNext, chanFirst;
  logic [HW-1:0]   hiByte;
  logic            halfSel;
  logic            frameDoneQ;
  logic            higherSel;
  logic [PW-1:0]   curPair, nextPair, firstPair;
  logic [NPAIRS-1:0] selQ, selIn;

  assign selQ    = cfgQ[CFGW-1 -: NPAIRS];
  assign selIn   = cfgIn[CFGW-1 -: NPAIRS];
  assign curPair = PW'(chanIdx >> 1);

  // lowest selected pair of the incoming configuration
  always_comb begin
    firstPair = '0;
    for (int i = NPAIRS - 1; i >= 0; i--) begin
      if (selIn[i]) firstPair = PW'(i);
    end
    chanFirst = CHW'({firstPair, 1'b0});
  end

  // next selected pair above the current one
  always_comb begin
    higherSel = 1'b0;
    nextPair  = curPair;
    for (int i = NPAIRS - 1; i >= 0; i--) begin
      if (selQ[i] && (PW'(i) > curPair)) begin
        higherSel = 1'b1;
        nextPair  = PW'(i);
      end
    end
    chanNext = chanIdx[0] ? CHW'({nextPair, 1'b0}) : chanIdx + 1'b1;
  end

  logic isLastChan;
  assign isLastChan = chanIdx[0] && !higherSel;

  assign dbOut          = {cfgQ, {(DW - CFGW){1'b0}}};
  assign stat.noPairs   = (selQ == '0);
  assign stat.frameDone = frameDoneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ       <= '0;
      byteQ      <= 1'b0;
      chanIdx    <= '0;
      hiByte     <= '0;
      halfSel    <= 1'b0;
      frameDoneQ <= 1'b0;
      resValid   <= 1'b0;
      resData    <= '0;
      resChan    <= '0;
      resLast    <= 1'b0;
    end else begin
      resValid <= 1'b0;
      resLast  <= 1'b0;
      if (strb.latchCfg) begin
        cfgQ       <= cfgIn;
        byteQ      <= byteModeIn;
        chanIdx    <= chanFirst;
        halfSel    <= 1'b0;
        frameDoneQ <= 1'b0;
      end else if (strb.sampleRd) begin
        if (byteQ && !halfSel) begin
          hiByte  <= dbIn[HW-1:0];
          halfSel <= 1'b1;
        end else begin
          resValid <= 1'b1;
          resData  <= byteQ ? {hiByte, dbIn[HW-1:0]} : dbIn;
          resChan  <= chanIdx;
          resLast  <= isLastChan;
          halfSel  <= 1'b0;
          chanIdx  <= chanNext;
          if (isLastChan) frameDoneQ <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
  import adc_seq_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WR_CYC    = 2,
  parameter int HOLD_CYC  = 1,
  parameter int CONV_CYC  = 2,
  parameter int RD_CYC    = 2,
  parameter int RDH_CYC   = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  cfgPairSel,
  input  logic [2:0]  cfgRange,
  input  logic        cfgIntRef,
  input  logic        cfgBufBypass,
  input  logic        byteMode,
  input  logic        busy,
  input  logic [15:0] dbIn,
  output logic [15:0] dbOut,
  output logic        dbOe,
  output logic        csN,
  output logic        wrN,
  output logic        rdN,
  output logic        convstA,
  output logic        convstB,
  output logic        convstC,
  output logic        resValid,
  output logic [15:0] resData,
  output logic [2:0]  resChan,
  output logic        resLast,
  output logic        done
);
  seqStrobe_t strb;
  seqStatus_t stat;

  assign convstB = 1'b0;
  assign convstC = 1'b0;

  adc_seq_ctrl #(
    .SETUP_CYC(SETUP_CYC), .WR_CYC(WR_CYC), .HOLD_CYC(HOLD_CYC),
    .CONV_CYC(CONV_CYC), .RD_CYC(RD_CYC), .RDH_CYC(RDH_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .stat(stat),
    .strb(strb), .csN(csN), .wrN(wrN), .rdN(rdN), .convst(convstA),
    .dbOe(dbOe), .done(done)
  );

  adc_seq_dp #(.NPAIRS(3), .DW(16)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgIn({cfgPairSel, cfgRange, cfgIntRef, cfgBufBypass}),
    .byteModeIn(byteMode), .dbIn(dbIn), .dbOut(dbOut), .stat(stat),
    .resValid(resValid), .resData(resData), .resChan(resChan),
    .resLast(resLast)
  );
endmodule

// File: rtl/adc_host_seq_chk.sv
module adc_host_seq_chk #(
  parameter int WR_CYC = 2,
  parameter int RD_CYC = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic [15:0] dbOut,
  input logic        dbOe,
  input logic        csN,
  input logic        wrN,
  input logic        rdN,
  input logic        convstA,
  input logic        convstB,
  input logic        convstC,
  input logic        resValid,
  input logic [2:0]  resChan,
  input logic        resLast,
  input logic        done
);
  int unsigned wrLowCnt, rdLowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrLowCnt <= 0;
      rdLowCnt <= 0;
    end else begin
      wrLowCnt <= wrN ? 0 : wrLowCnt + 1;
      rdLowCnt <= rdN ? 0 : rdLowCnt + 1;
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      a_r3_reset_idle: assert (csN && wrN && rdN && !convstA && !dbOe && !resValid && !done)
        else $error("R3 outputs not idle in reset");
    end
  end

  a_r1_write_frame: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (!csN && rdN && dbOe));
  a_r2_hold_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrN) |-> ($stable(dbOut) && dbOe));
  a_r4_other_starts_low: assert property (@(posedge clk) disable iff (!rstN)
    !convstB && !convstC);
  a_r5_no_read_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !busy);
  a_r6_release_before_read: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> !$past(dbOe));
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    dbOe |-> rdN);
  a_r7_chan_range: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resChan <= 3'd5));
  a_r9_last_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    resLast |-> resValid);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r12_wr_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrN) |-> (wrLowCnt == WR_CYC));
  a_r12_rd_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdN) |-> (rdLowCnt == RD_CYC));
endmodule

bind adc_host_seq adc_host_seq_chk #(.WR_CYC(WR_CYC), .RD_CYC(RD_CYC)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .dbOut(dbOut), .dbOe(dbOe),
  .csN(csN), .wrN(wrN), .rdN(rdN), .convstA(convstA), .convstB(convstB),
  .convstC(convstC), .resValid(resValid), .resChan(resChan),
  .resLast(resLast), .done(done)
);

// File: tb/sim_adc_host_seq.sv
`timescale 1ns/1ps
module sim_adc_host_seq;
  localparam int P_WR = 3;
  localparam int P_RD = 2;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [2:0] cfgPairSel = '0, cfgRange = '0;
  logic cfgIntRef = 1'b0, cfgBufBypass = 1'b0, byteMode = 1'b0;
  logic busy = 1'b0;
  logic [15:0] dbIn = '0;
  logic [15:0] dbOut, resData;
  logic dbOe, csN, wrN, rdN, convstA, convstB, convstC, resValid, resLast, done;
  logic [2:0] resChan;

  adc_host_seq #(.SETUP_CYC(1), .WR_CYC(P_WR), .HOLD_CYC(2), .CONV_CYC(2),
                 .RD_CYC(P_RD), .RDH_CYC(1)) u0 (.*);

  always #2.5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  logic [7:0] capByte = '0;
  int wrRises = 0, convRises = 0, rdFalls = 0, doneCnt = 0;
  int mdlList[6];
  int mdlN = 0, rdIdx = 0, curSeed = 0;

  function automatic logic [15:0] wordVal(input int c, input int seed);
    return 16'((c * 16'h2301) + (seed * 16'h0111) + 16'h0A5C);
  endfunction

  always @(posedge wrN) if (!csN) begin
    capByte = dbOut[15:8];
    wrRises++;
    mdlN = 0;
    rdIdx = 0;
    for (int p = 0; p < 3; p++) if (capByte[5 + p]) begin
      mdlList[mdlN] = 2 * p; mdlList[mdlN + 1] = 2 * p + 1; mdlN += 2;
    end
  end

  always @(posedge convstA) begin
    convRises++;
    repeat (3) @(posedge clk);
    busy <= 1'b1;
    repeat (10) @(posedge clk);
    busy <= 1'b0;
  end

  always @(negedge rdN) begin
    int k;
    logic [15:0] w;
    rdFalls++;
    k = rdIdx;
    if (byteMode) begin
      w = wordVal(mdlList[(k / 2) % 6], curSeed);
      dbIn = {8'hEE, (k % 2 == 0) ? w[15:8] : w[7:0]};
    end else begin
      dbIn = wordVal(mdlList[k % 6], curSeed);
    end
    rdIdx++;
  end

  // ---------------- monitors ----------------
  logic [15:0] gotData[16];
  logic [2:0]  gotChan[16];
  logic        gotLast[16];
  int gotN = 0, badOe = 0, badBusy = 0, wrRun = 0, rdRun = 0, lastWrW = 0, lastRdW = 0;
  logic prevRdN = 1'b1, prevOe = 1'b0;

  always @(negedge clk) if (rstN) begin
    if (resValid && gotN < 16) begin
      gotData[gotN] = resData; gotChan[gotN] = resChan; gotLast[gotN] = resLast; gotN++;
    end
    if (done) doneCnt++;
    if (dbOe && !rdN) badOe++;
    if (!rdN && prevRdN && prevOe) badOe++;
    if (!rdN && busy) badBusy++;
    prevRdN = rdN; prevOe = dbOe;
    if (!wrN) wrRun++; else if (wrRun > 0) begin lastWrW = wrRun; wrRun = 0; end
    if (!rdN) rdRun++; else if (rdRun > 0) begin lastRdW = rdRun; rdRun = 0; end
  end

  // ---------------- scenarios ----------------
  task automatic runFrame(input logic [2:0] sel, input logic [2:0] rng, input bit ir,
                          input bit bp, input bit bm, input int seed, input bit restartMid);
    int wrB, cvB, rdB, dnB, np, waitC, expReads;
    logic [7:0] expByte;
    @(negedge clk);
    cfgPairSel = sel; cfgRange = rng; cfgIntRef = ir; cfgBufBypass = bp;
    byteMode = bm; curSeed = seed;
    wrB = wrRises; cvB = convRises; rdB = rdFalls; dnB = doneCnt; gotN = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restartMid) begin
      repeat (8) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitC = 0;
    while (doneCnt == dnB && waitC < 3000) begin @(negedge clk); waitC++; end
    chk(doneCnt == dnB + 1, "R11 done pulse", doneCnt - dnB, 1);
    repeat (4) @(negedge clk);
    chk(doneCnt == dnB + 1, "R11 single done", doneCnt - dnB, 1);
    np = 0;
    for (int p = 0; p < 3; p++) if (sel[p]) np++;
    expByte = {sel[2], sel[1], sel[0], rng[2], rng[1], rng[0], ir, bp};
    chk(capByte == expByte, "R1 control byte", capByte, expByte);
    chk(wrRises == wrB + 1, "R11 one write per frame", wrRises - wrB, 1);
    chk(convRises == cvB + ((np > 0) ? 1 : 0), "R4/R10 convst pulses", convRises - cvB, (np > 0) ? 1 : 0);
    expReads = 2 * np * (bm ? 2 : 1);
    chk(rdFalls == rdB + expReads, "R5/R10 read count", rdFalls - rdB, expReads);
    chk(gotN == 2 * np, "R7 result count", gotN, 2 * np);
    begin
      int idx = 0;
      for (int p = 0; p < 3; p++) if (sel[p]) begin
        for (int h = 0; h < 2; h++) begin
          int c = 2 * p + h;
          if (idx < gotN) begin
            chk(gotChan[idx] == 3'(c), "R7 channel order", gotChan[idx], c);
            chk(gotData[idx] == wordVal(c, seed), bm ? "R8 byte merge" : "R7 word data",
                gotData[idx], wordVal(c, seed));
            chk(gotLast[idx] == (idx == 2 * np - 1), "R9 last flag", gotLast[idx], idx == 2 * np - 1);
          end
          idx++;
        end
      end
    end
  endtask

  task automatic tReset();
    @(negedge clk);
    chk(csN && wrN && rdN, "R3 strobes high in reset", {csN, wrN, rdN}, 3'b111);
    chk(!convstA && !dbOe && !resValid && !done, "R3 outputs low in reset",
        {convstA, dbOe, resValid, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN && wrN && rdN && !dbOe && !convstA, "R3 idle after reset",
        {csN, wrN, rdN, dbOe, convstA}, 5'b11100);
  endtask

  task automatic tWidths();
    chk(lastWrW == P_WR, "R12 write low width", lastWrW, P_WR);
    chk(lastRdW == P_RD, "R12 read low width", lastRdW, P_RD);
  endtask

  task automatic tBusRules();
    chk(badOe == 0, "R6 bus released before reads", badOe, 0);
    chk(badBusy == 0, "R5 no read while busy", badBusy, 0);
    chk(!convstB && !convstC, "R4 other starts low", {convstB, convstC}, 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    runFrame(3'b111, 3'b000, 1'b0, 1'b0, 1'b0, 1, 1'b0);  // R7 all pairs word
    tWidths();
    runFrame(3'b101, 3'b101, 1'b1, 1'b0, 1'b0, 2, 1'b0);  // R7 skip middle pair
    runFrame(3'b010, 3'b011, 1'b0, 1'b1, 1'b1, 3, 1'b0);  // R8 byte, single pair
    runFrame(3'b111, 3'b111, 1'b1, 1'b1, 1'b1, 4, 1'b0);  // R8 byte, all pairs
    tWidths();
    runFrame(3'b000, 3'b110, 1'b1, 1'b0, 1'b0, 5, 1'b0);  // R10 empty selection
    runFrame(3'b011, 3'b000, 1'b0, 1'b1, 1'b0, 6, 1'b1);  // R11 restart ignored
    runFrame(3'b001, 3'b010, 1'b1, 1'b0, 1'b0, 7, 1'b0);  // R1 bit positions
    tBusRules();
    finish();
  end
endmodule